// File: doc/BRIEF.md
# Reset Pulse Generator with Sticky Cause Flags

This block owns an active-low system reset line and records what pulled it down. Three events can start a reset: a manual request sensed on the reset line itself, a digital low-supply indication, and a fault strobe from a watchdog. Every accepted event produces a low pulse of fixed length. The length is set as a number of ticks of an internal timebase, and each tick lasts a set number of clock cycles. While the low-supply indication is active the line stays low. Once the indication drops, the line stays low for one further full pulse.

The line is modelled as two signals: a sensed level coming in and a drive level going out. The sensed level is debounced over a parameterised number of consecutive samples. It is only watched while the block is not driving the line, so the block's own pulse cannot start another one. When each pulse ends, the block sends a one-cycle restart strobe to the watchdog.

Two sticky cause flags live in one byte-wide register, reached through a small read/write port. Hardware only ever sets these flags. Software clears a flag by writing a zero to its bit.

Top module: `rstPulseGen`

## Requirements
- R1: After the block reset, `rstDriveN` is 1, `wdRestart` is 0 and the flag register reads 8'h00.
- R2: While the line is not driven, a sensed low starts a pulse only after DEB_SAMPLES consecutive low samples. A shorter low run starts nothing.
- R3: A pulse started by a manual or watchdog event keeps `rstDriveN` at 0 for exactly TICK_DIV*PULSE_TICKS clock cycles.
- R4: The sensed level is ignored while the block drives the line. After a pulse, the debounce count starts again from zero.
- R5: A `wdFault` strobe while `wdEnable` is 1 starts a pulse. With `wdEnable` at 0 the same strobe starts no pulse.
- R6: `supplyLow` drives the line low from the next cycle for as long as it stays at 1. After it falls, the line is released only once a full pulse has elapsed.
- R7: A low-supply or manual event sets the supply/manual flag, which is bit 6 of the register at address FLAG_ADDR (default 9).
- R8: Any `wdFault` strobe sets the watchdog flag, bit 7 of the same register, whether `wdEnable` is 1 or 0.
- R9: A write to FLAG_ADDR with data bit 6 or bit 7 at 0 clears that flag. Writing a 1, or writing any other address, leaves the flags unchanged. A set event in the same cycle wins over the clear.
- R10: Both flags can read as 1 together (8'hC0).
- R11: `wdRestart` is 1 for exactly the one cycle in which `rstDriveN` returns to 1.
- R12: A read of FLAG_ADDR returns {watchdog flag, supply/manual flag, 6'b0}. Any other address reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arstN | input | 1 | Asynchronous active-low reset of the block's own state |
| rstSenseN | input | 1 | Sensed level of the reset line |
| rstDriveN | output | 1 | Drive of the reset line; 0 pulls it low |
| supplyLow | input | 1 | Digital low-supply indication |
| wdFault | input | 1 | Watchdog timeout strobe |
| wdEnable | input | 1 | Lets a watchdog fault drive the reset line |
| wdRestart | output | 1 | One-cycle watchdog restart at pulse release |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |

## Verification
The hardest case to reach is where the debounce has to start over after a pulse. The line must have been sensed low for the whole pulse and still be low during the first cycle after release. The bench models the line as the external switch ANDed with the block's own drive. It holds the switch down through an entire pulse and lets go one cycle after release. A debounce that kept counting during the drive would then start a second pulse straight away. The bench also lines up a clear write with a fault strobe in the same cycle, and raises the low-supply indication in the middle of a running pulse. A cycle-accurate reference model checks every one of these states.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_PULSE} rpgState_t;

  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic debEn;
    logic porSet;
    logic wtrSet;
  } rpgStrb_t;

  localparam int POR_BIT = 6;
  localparam int WTR_BIT = 7;
endpackage

// File: rtl/rpg_ctrl.sv
module rpg_ctrl
  import rpg_pkg::*;
(
  input  logic     clk,
  input  logic     arstN,
  input  logic     supplyLow,
  input  logic     wdFault,
  input  logic     wdEnable,
  input  logic     manualEvt,
  input  logic     pulseDone,
  output rpgStrb_t strb,
  output logic     rstDriveN,
  output logic     wdRestart
);
  rpgState_t state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (supplyLow) nxt = ST_HOLD;
                else if (manualEvt || (wdFault && wdEnable)) nxt = ST_PULSE;
      ST_HOLD:  if (!supplyLow) nxt = ST_PULSE;
      ST_PULSE: if (supplyLow) nxt = ST_HOLD;
                else if (pulseDone) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.cntClr = (nxt == ST_PULSE) && (state != ST_PULSE);
    strb.cntRun = (state == ST_PULSE);
    strb.debEn  = (state == ST_IDLE);
    strb.porSet = supplyLow || manualEvt;
    strb.wtrSet = wdFault;
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      state     <= ST_IDLE;
      wdRestart <= 1'b0;
    end else begin
      state     <= nxt;
      wdRestart <= (state != ST_IDLE) && (nxt == ST_IDLE);
    end
  end

  assign rstDriveN = (state == ST_IDLE);

  p_hold_supply_r6: assert property (@(posedge clk) disable iff (!arstN)
    supplyLow |=> !rstDriveN);
  p_wd_start_r5: assert property (@(posedge clk) disable iff (!arstN)
    (rstDriveN && wdFault && wdEnable) |=> !rstDriveN);
  p_restart_at_rise_r11: assert property (@(posedge clk) disable iff (!arstN)
    $rose(rstDriveN) |-> wdRestart);
  p_restart_only_rise_r11: assert property (@(posedge clk) disable iff (!arstN)
    wdRestart |-> $rose(rstDriveN));
endmodule

// File: rtl/rpg_datapath.sv
module rpg_datapath
  import rpg_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int PULSE_TICKS = 100,
  parameter int DEB_SAMPLES = 16,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int FLAG_ADDR   = 9
) (
  input  logic              clk,
  input  logic              arstN,
  input  rpgStrb_t          strb,
  input  logic              rstSenseN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              manualEvt,
  output logic              pulseDone
);
  localparam int DIV_W  = (TICK_DIV    > 1) ? $clog2(TICK_DIV)    : 1;
  localparam int TICK_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam int DEB_W  = (DEB_SAMPLES > 1) ? $clog2(DEB_SAMPLES) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(TICK_DIV - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(PULSE_TICKS - 1);
  localparam logic [DEB_W-1:0]  DEB_LAST  = DEB_W'(DEB_SAMPLES - 1);
  localparam logic [ADDR_W-1:0] FLAG_A    = ADDR_W'(FLAG_ADDR);

  logic [DIV_W-1:0]  divCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [DEB_W-1:0]  debCnt;
  logic porFlag, wtrFlag, flagWr;

  // Pulse timebase: restarted at every pulse entry so the length is exact.
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (strb.cntClr) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (strb.cntRun) begin
      if (divCnt == DIV_LAST) begin
        divCnt  <= '0;
        tickCnt <= tickCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign pulseDone = strb.cntRun && (divCnt == DIV_LAST) && (tickCnt == TICK_LAST);

  // Debounce of the sensed line, only while the block is not driving it.
  assign manualEvt = strb.debEn && !rstSenseN && (debCnt == DEB_LAST);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                                     debCnt <= '0;
    else if (!strb.debEn || rstSenseN || manualEvt) debCnt <= '0;
    else                                            debCnt <= debCnt + 1'b1;
  end

  // Sticky cause flags: set by hardware, cleared by writing zero.
  assign flagWr = regWrEn && (regAddr == FLAG_A);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      porFlag <= 1'b0;
      wtrFlag <= 1'b0;
    end else begin
      porFlag <= strb.porSet | (porFlag & ~(flagWr & ~regWrData[POR_BIT]));
      wtrFlag <= strb.wtrSet | (wtrFlag & ~(flagWr & ~regWrData[WTR_BIT]));
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == FLAG_A) begin
      regRdData[POR_BIT] = porFlag;
      regRdData[WTR_BIT] = wtrFlag;
    end
  end

  p_por_set_r7: assert property (@(posedge clk) disable iff (!arstN)
    strb.porSet |=> porFlag);
  p_wtr_set_r8: assert property (@(posedge clk) disable iff (!arstN)
    strb.wtrSet |=> wtrFlag);
  p_por_keep_r9: assert property (@(posedge clk) disable iff (!arstN)
    (porFlag && !(flagWr && !regWrData[POR_BIT])) |=> porFlag);
  p_wtr_keep_r9: assert property (@(posedge clk) disable iff (!arstN)
    (wtrFlag && !(flagWr && !regWrData[WTR_BIT])) |=> wtrFlag);
endmodule

// File: rtl/rstPulseGen.sv
module rstPulseGen
  import rpg_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int PULSE_TICKS = 100,
  parameter int DEB_SAMPLES = 16,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int FLAG_ADDR   = 9
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic              rstSenseN,
  output logic              rstDriveN,
  input  logic              supplyLow,
  input  logic              wdFault,
  input  logic              wdEnable,
  output logic              wdRestart,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  rpgStrb_t strb;
  logic manualEvt, pulseDone;

  rpg_ctrl uCtrl (
    .clk(clk), .arstN(arstN), .supplyLow(supplyLow), .wdFault(wdFault),
    .wdEnable(wdEnable), .manualEvt(manualEvt), .pulseDone(pulseDone),
    .strb(strb), .rstDriveN(rstDriveN), .wdRestart(wdRestart)
  );

  rpg_datapath #(
    .TICK_DIV(TICK_DIV), .PULSE_TICKS(PULSE_TICKS), .DEB_SAMPLES(DEB_SAMPLES),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR)
  ) uData (
    .clk(clk), .arstN(arstN), .strb(strb), .rstSenseN(rstSenseN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .manualEvt(manualEvt), .pulseDone(pulseDone)
  );
endmodule

// File: tb/rstPulseGen_test.sv
module rstPulseGen_test;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int PTK  = 3;
  localparam int DEB  = 3;
  localparam int PLEN = TDIV * PTK;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic btnN = 1'b1;
  logic supplyLow = 1'b0, wdFault = 1'b0, wdEnable = 1'b0, regWrEn = 1'b0;
  logic [3:0] regAddr = 4'd9;
  logic [7:0] regWrData = 8'h00;
  logic rstDriveN, wdRestart, rstSenseN;
  logic [7:0] regRdData;

  assign rstSenseN = btnN & rstDriveN;  // wired line: switch plus own drive

  always #(CLK_PERIOD/2) clk = ~clk;

  rstPulseGen #(.TICK_DIV(TDIV), .PULSE_TICKS(PTK), .DEB_SAMPLES(DEB),
                .ADDR_W(4), .DATA_W(8), .FLAG_ADDR(9)) uut (
    .clk(clk), .arstN(arstN), .rstSenseN(rstSenseN), .rstDriveN(rstDriveN),
    .supplyLow(supplyLow), .wdFault(wdFault), .wdEnable(wdEnable),
    .wdRestart(wdRestart), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  int cmpCount = 0, cmpFail = 0, chkCount = 0, chkFail = 0;
  string phase = "R1";

  // Reference model: 0 idle, 1 held by supply, 2 timed pulse
  int mState = 0, mLeft = 0, mDeb = 0;
  bit mPor = 0, mWtr = 0, mRestart = 0;

  always @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      mState = 0; mLeft = 0; mDeb = 0; mPor = 0; mWtr = 0; mRestart = 0;
    end else begin
      automatic bit idle = (mState == 0);
      automatic bit sense = btnN & idle;
      automatic bit manual = idle && !sense && (mDeb == DEB - 1);
      automatic int ns = mState;
      if (regWrEn && regAddr == 4'd9) begin
        mPor = mPor & regWrData[6];
        mWtr = mWtr & regWrData[7];
      end
      if (supplyLow || manual) mPor = 1;
      if (wdFault) mWtr = 1;
      mDeb = (idle && !sense && !manual) ? mDeb + 1 : 0;
      if (supplyLow) ns = 1;
      else if (mState == 0) begin
        if (manual || (wdFault && wdEnable)) begin ns = 2; mLeft = PLEN; end
      end else if (mState == 1) begin
        ns = 2; mLeft = PLEN;
      end else begin
        if (mLeft == 1) ns = 0; else mLeft = mLeft - 1;
      end
      mRestart = (mState != 0) && (ns == 0);
      mState = ns;
    end
  end

  always @(negedge clk) begin
    if (arstN) begin
      automatic logic [7:0] expRd = (regAddr == 4'd9) ? {mWtr, mPor, 6'b0} : 8'h00;
      automatic logic expDrv = (mState == 0);
      cmpCount++;
      if (rstDriveN !== expDrv || wdRestart !== mRestart || regRdData !== expRd) begin
        cmpFail++;
        $display("FAIL %s model: drv=%b rst=%b rd=%h expected drv=%b rst=%b rd=%h",
                 phase, rstDriveN, wdRestart, regRdData, expDrv, mRestart, expRd);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chkCount++;
    if (!ok) begin
      chkFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // counts low cycles seen at the following negedges; returns at the first high one
  task automatic measureLow(output int cnt);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rstDriveN) break;
      cnt++;
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step(1);
    regWrEn = 1'b0; regAddr = 4'd9;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             cmpCount + chkCount, cmpFail + chkFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chkFail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int len;
    step(3);
    arstN = 1'b1;
    @(negedge clk);
    check(rstDriveN === 1'b1 && wdRestart === 1'b0 && regRdData === 8'h00, "R1 reset state",
          {rstDriveN, wdRestart, regRdData}, 10'h200);
    step(1);

    phase = "R2";
    btnN = 1'b0; step(DEB - 1); btnN = 1'b1; step(6);
    @(negedge clk);
    check(rstDriveN === 1'b1, "R2 short glitch ignored", rstDriveN, 1);
    step(1);

    phase = "R3";
    btnN = 1'b0; step(DEB);
    measureLow(len);
    check(len == PLEN, "R3 manual pulse length", len, PLEN);
    check(wdRestart === 1'b1, "R11 restart at release", wdRestart, 1);
    step(1);
    phase = "R4";
    btnN = 1'b1;
    @(negedge clk);
    check(wdRestart === 1'b0, "R11 restart one cycle", wdRestart, 0);
    step(2 * DEB);
    @(negedge clk);
    check(rstDriveN === 1'b1, "R4 no retrigger after drive", rstDriveN, 1);
    check(regRdData === 8'h40, "R7 manual sets bit 6", regRdData, 8'h40);
    step(1);

    phase = "R9";
    writeReg(4'd9, 8'hFF);
    writeReg(4'd3, 8'h00);
    @(negedge clk);
    check(regRdData === 8'h40, "R9 ones or other address keep flag", regRdData, 8'h40);
    regAddr = 4'd3;
    #1;
    check(regRdData === 8'h00, "R12 other address reads zero", regRdData, 0);
    step(1);
    writeReg(4'd9, 8'h80);
    @(negedge clk);
    check(regRdData === 8'h00, "R9 zero clears bit 6", regRdData, 0);
    step(1);

    phase = "R8";
    wdEnable = 1'b0; wdFault = 1'b1; step(1); wdFault = 1'b0; step(4);
    @(negedge clk);
    check(rstDriveN === 1'b1, "R5 disabled fault no pulse", rstDriveN, 1);
    check(regRdData === 8'h80, "R8 fault sets bit 7", regRdData, 8'h80);
    step(1);

    phase = "R5";
    wdEnable = 1'b1; wdFault = 1'b1; step(1); wdFault = 1'b0;
    measureLow(len);
    check(len == PLEN, "R5 enabled fault pulse length", len, PLEN);
    step(3);

    phase = "R9";
    wdEnable = 1'b0;
    regAddr = 4'd9; regWrData = 8'h00; regWrEn = 1'b1; wdFault = 1'b1;
    step(1);
    regWrEn = 1'b0; wdFault = 1'b0;
    @(negedge clk);
    check(regRdData === 8'h80, "R9 set beats clear", regRdData, 8'h80);
    step(1);
    writeReg(4'd9, 8'h00);
    @(negedge clk);
    check(regRdData === 8'h00, "R9 clear both", regRdData, 0);
    step(1);

    phase = "R6";
    supplyLow = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (i == 5) begin wdEnable = 1'b1; wdFault = 1'b1; end
      else wdFault = 1'b0;
      @(negedge clk);
      check(rstDriveN === 1'b0, "R6 held while supply low", rstDriveN, 0);
    end
    step(1);
    supplyLow = 1'b0; wdFault = 1'b0;
    measureLow(len);
    check(len == PLEN + 1, "R6 full pulse after supply", len, PLEN + 1);
    check(regRdData === 8'hC0, "R10 both flags", regRdData, 8'hC0);
    step(2);

    phase = "R6";
    wdFault = 1'b1; step(1); wdFault = 1'b0; step(5);
    supplyLow = 1'b1; step(3); supplyLow = 1'b0;
    measureLow(len);
    check(len == PLEN + 1, "R6 supply during pulse extends", len, PLEN + 1);
    step(5);
    summary();
  end
endmodule